// File: doc/BRIEF.md
# Directory Trap Filter

This block sits between the network input and a hardware coherence directory. For every memory block it keeps a two-bit handling mode. Each incoming coherence packet names a directory entry and a message type, and the block steers it to one of three places. It can go to the hardware directory. It can be handed to software through the interprocessor input queue. Or it can be held back because software still owns that entry.

A handoff to software moves the entry into a locked mode. The entry stays locked until software writes a new mode through the configuration port. Software uses the same port to switch an entry into write-trapping or full-trapping modes once a sharer list has overflowed. It also uses it to return the entry to hardware handling when emulation ends. The block stores the modes and makes the routing decision. The full sharer bit vector and the handler code live outside it.

Top module: `dirf_trap_filter`

## Requirements
- R1: After reset every entry reads back mode 0 (hardware) on `cfg_mode_o`.
- R2: In mode 0, a packet with `pkt_ovf_i` low goes to hardware: `hw_valid_o`=1 and `pkt_ready_o`=1, whatever the opcode.
- R3: In mode 0, a packet with `pkt_ovf_i` high (sharer pointers exhausted) is forwarded to software. If `sw_ready_i` is high, the entry becomes mode 1 (locked) from the next cycle.
- R4: In mode 2 (trap writes), opcodes 1 (write request), 2 (replace modified) and 3 (update) are forwarded to software, and an accepted forward locks the entry. All other opcodes (0 read request, 4 invalidate ack, 5 to 7) go to hardware.
- R5: In mode 3 (trap all), every packet is forwarded to software, and an accepted forward locks the entry.
- R6: In mode 1 (locked), no packet reaches hardware or software. While `sw_ready_i` is high the packet is stalled (`pkt_ready_o`=0, `busy_o`=0). While `sw_ready_i` is low it is answered with `busy_o`=1 and consumed (`pkt_ready_o`=1).
- R7: A forward that meets `sw_ready_i` low stalls (`sw_valid_o`=1, `pkt_ready_o`=0) and leaves the entry's mode unchanged.
- R8: A configuration write (`cfg_we_i`) stores `cfg_mode_i` into entry `cfg_idx_i` from the next cycle. `cfg_mode_o` shows the stored mode of `cfg_idx_i` in the same cycle.
- R9: A configuration write to the entry being locked in the same cycle wins: the written mode is stored, not mode 1.
- R10: A forward changes only the mode of the packet's own entry.
- R11: A packet routed to hardware leaves its entry's mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Incoming packet present |
| pkt_idx_i | input | IDX_W | Directory entry of the packet |
| pkt_op_i | input | 3 | Message opcode |
| pkt_ovf_i | input | 1 | Hardware sharer pointers would overflow |
| pkt_ready_o | output | 1 | Packet consumed this cycle |
| hw_valid_o | output | 1 | Packet steered to hardware directory |
| sw_valid_o | output | 1 | Packet steered to software input queue |
| sw_ready_i | input | 1 | Software input queue has room |
| busy_o | output | 1 | Reply BUSY to the sender |
| cfg_we_i | input | 1 | Mode write strobe |
| cfg_idx_i | input | IDX_W | Entry for write and read-back |
| cfg_mode_i | input | 2 | Mode to write |
| cfg_mode_o | output | 2 | Current mode of entry `cfg_idx_i` |

## Verification
A corrupted mode shows up at the ports in the very next packet to that entry. A wrongly cleared lock leaks a packet to `hw_valid_o` or `sw_valid_o`. A lock that was never set lets a second write forward through, and a stuck lock turns hardware traffic into stalls or BUSY replies. The read-back port exposes every stored mode combinationally, so any wrong update is visible one cycle after the edge that caused it. The bench checks routing every cycle and reads a random entry every cycle.

// File: rtl/dirf_pkg.sv
package dirf_pkg;
  localparam int OP_W = 3;

  typedef enum logic [1:0] {
    MODE_HW       = 2'd0,
    MODE_LOCKED   = 2'd1,
    MODE_TRAP_WR  = 2'd2,
    MODE_TRAP_ALL = 2'd3
  } mode_e;

  localparam logic [OP_W-1:0] OP_RD_REQ = 3'd0;
  localparam logic [OP_W-1:0] OP_WR_REQ = 3'd1;
  localparam logic [OP_W-1:0] OP_REPL   = 3'd2;
  localparam logic [OP_W-1:0] OP_UPD    = 3'd3;
  localparam logic [OP_W-1:0] OP_INVACK = 3'd4;
endpackage

// File: rtl/dirf_mode_store.sv
module dirf_mode_store
  import dirf_pkg::*;
#(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lock_i,
  input  logic [IDX_W-1:0]     lock_idx_i,
  input  logic                 cfg_we_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  mode_e                cfg_mode_i,
  input  logic [IDX_W-1:0]     pkt_idx_i,
  output mode_e                pkt_mode_o,
  output mode_e                cfg_mode_o,
  output logic [2*ENTRIES-1:0] mode_flat_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    mode_e m_q;
    logic  wr_hit, lock_hit;
    assign wr_hit   = cfg_we_i && (cfg_idx_i == IDX_W'(g));
    assign lock_hit = lock_i && (lock_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       m_q <= MODE_HW;
      else if (wr_hit)   m_q <= cfg_mode_i;   // software write outranks lock
      else if (lock_hit) m_q <= MODE_LOCKED;
    end

    assign mode_flat_o[2*g +: 2] = m_q;
  end

  assign pkt_mode_o = mode_e'(mode_flat_o[{pkt_idx_i, 1'b0} +: 2]);
  assign cfg_mode_o = mode_e'(mode_flat_o[{cfg_idx_i, 1'b0} +: 2]);
endmodule

// File: rtl/dirf_route.sv
module dirf_route
  import dirf_pkg::*;
(
  input  logic            valid_i,
  input  mode_e           mode_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            ovf_i,
  input  logic            sw_ready_i,
  output logic            hw_o,
  output logic            sw_o,
  output logic            busy_o,
  output logic            ready_o,
  output logic            lock_o
);
  logic write_class;
  logic to_sw;

  assign write_class = (op_i == OP_WR_REQ) || (op_i == OP_REPL) || (op_i == OP_UPD);

  always_comb begin
    to_sw = 1'b0;
    unique case (mode_i)
      MODE_HW:       to_sw = ovf_i;
      MODE_TRAP_WR:  to_sw = write_class;
      MODE_TRAP_ALL: to_sw = 1'b1;
      default:       to_sw = 1'b0;
    endcase
  end

  always_comb begin
    hw_o   = 1'b0;
    sw_o   = 1'b0;
    busy_o = 1'b0;
    if (valid_i) begin
      if (mode_i == MODE_LOCKED) busy_o = !sw_ready_i;  // queue full: bounce
      else if (to_sw)            sw_o   = 1'b1;
      else                       hw_o   = 1'b1;
    end
  end

  assign lock_o  = sw_o && sw_ready_i;
  assign ready_o = hw_o || lock_o || busy_o;
endmodule

// File: rtl/dirf_trap_filter.sv
module dirf_trap_filter
  import dirf_pkg::*;
#(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_valid_i,
  input  logic [IDX_W-1:0] pkt_idx_i,
  input  logic [OP_W-1:0]  pkt_op_i,
  input  logic             pkt_ovf_i,
  output logic             pkt_ready_o,
  output logic             hw_valid_o,
  output logic             sw_valid_o,
  input  logic             sw_ready_i,
  output logic             busy_o,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [1:0]       cfg_mode_i,
  output logic [1:0]       cfg_mode_o
);
  mode_e                pkt_mode;
  mode_e                rd_mode;
  logic                 lock;
  logic [2*ENTRIES-1:0] mode_flat;

  dirf_mode_store #(.ENTRIES(ENTRIES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_i      (lock),
    .lock_idx_i  (pkt_idx_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_mode_i  (mode_e'(cfg_mode_i)),
    .pkt_idx_i   (pkt_idx_i),
    .pkt_mode_o  (pkt_mode),
    .cfg_mode_o  (rd_mode),
    .mode_flat_o (mode_flat)
  );

  dirf_route u_route (
    .valid_i    (pkt_valid_i),
    .mode_i     (pkt_mode),
    .op_i       (pkt_op_i),
    .ovf_i      (pkt_ovf_i),
    .sw_ready_i (sw_ready_i),
    .hw_o       (hw_valid_o),
    .sw_o       (sw_valid_o),
    .busy_o     (busy_o),
    .ready_o    (pkt_ready_o),
    .lock_o     (lock)
  );

  assign cfg_mode_o = rd_mode;
endmodule

// File: rtl/dirf_trap_filter_chk.sv
module dirf_trap_filter_chk #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 pkt_valid_i,
  input logic [IDX_W-1:0]     pkt_idx_i,
  input logic [2:0]           pkt_op_i,
  input logic                 pkt_ovf_i,
  input logic                 pkt_ready_o,
  input logic                 hw_valid_o,
  input logic                 sw_valid_o,
  input logic                 sw_ready_i,
  input logic                 busy_o,
  input logic                 cfg_we_i,
  input logic [IDX_W-1:0]     cfg_idx_i,
  input logic [1:0]           cfg_mode_i,
  input logic [2*ENTRIES-1:0] mode_flat
);
  function automatic logic [1:0] m_of(input logic [2*ENTRIES-1:0] f, input logic [IDX_W-1:0] i);
    return f[{i, 1'b0} +: 2];
  endfunction

  logic [1:0] cur;
  logic       coll;
  assign cur  = m_of(mode_flat, pkt_idx_i);
  assign coll = cfg_we_i && (cfg_idx_i == pkt_idx_i);

  AST_ONE_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hw_valid_o, sw_valid_o, busy_o})); // R6
  AST_LOCKED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && cur == 2'd1) |-> (!hw_valid_o && !sw_valid_o)); // R6
  AST_BUSY_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!sw_ready_i && pkt_ready_o)); // R6
  AST_HW_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && cur == 2'd0 && !pkt_ovf_i) |-> (hw_valid_o && pkt_ready_o)); // R2
  AST_TRAP_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && cur == 2'd3) |-> sw_valid_o); // R5
  AST_FWD_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_valid_o && sw_ready_i && !coll) |=> (m_of(mode_flat, $past(pkt_idx_i)) == 2'd1)); // R3
  AST_STALL_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_valid_o && !sw_ready_i && !coll) |=> (m_of(mode_flat, $past(pkt_idx_i)) == $past(cur))); // R7
  AST_CFG_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (m_of(mode_flat, $past(cfg_idx_i)) == $past(cfg_mode_i))); // R9
  AST_HW_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_valid_o && !coll) |=> (m_of(mode_flat, $past(pkt_idx_i)) == $past(cur))); // R11
endmodule

bind dirf_trap_filter dirf_trap_filter_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pkt_valid_i (pkt_valid_i),
  .pkt_idx_i   (pkt_idx_i),
  .pkt_op_i    (pkt_op_i),
  .pkt_ovf_i   (pkt_ovf_i),
  .pkt_ready_o (pkt_ready_o),
  .hw_valid_o  (hw_valid_o),
  .sw_valid_o  (sw_valid_o),
  .sw_ready_i  (sw_ready_i),
  .busy_o      (busy_o),
  .cfg_we_i    (cfg_we_i),
  .cfg_idx_i   (cfg_idx_i),
  .cfg_mode_i  (cfg_mode_i),
  .mode_flat   (mode_flat)
);

// File: tb/dirf_trap_filter_test.sv
`timescale 1ns/1ps
module dirf_trap_filter_test;
  localparam int ENTRIES = 16;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pkt_valid_i = 1'b0;
  logic [IDX_W-1:0] pkt_idx_i = '0;
  logic [2:0]       pkt_op_i = '0;
  logic             pkt_ovf_i = 1'b0;
  logic             pkt_ready_o, hw_valid_o, sw_valid_o, busy_o;
  logic             sw_ready_i = 1'b1;
  logic             cfg_we_i = 1'b0;
  logic [IDX_W-1:0] cfg_idx_i = '0;
  logic [1:0]       cfg_mode_i = '0;
  logic [1:0]       cfg_mode_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] exp_mode [ENTRIES];

  always #2.5 clk_i = ~clk_i;

  dirf_trap_filter #(.ENTRIES(ENTRIES)) uut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // {hw, sw, busy, ready}
  function automatic logic [3:0] exp_route(input logic v, input logic [1:0] m, input logic [2:0] op,
                                           input logic ovf, input logic rdy);
    logic need;
    if (!v) return 4'b0000;
    if (m == 2'd1) return {1'b0, 1'b0, !rdy, !rdy};
    need = (m == 2'd3) || (m == 2'd0 && ovf) || (m == 2'd2 && (op == 3'd1 || op == 3'd2 || op == 3'd3));
    if (need) return {1'b0, 1'b1, 1'b0, rdy};
    return 4'b1001;
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic need_rdy_low);
    if (m == 2'd1) return "R6";
    if (need_rdy_low) return "R7";
    case (m)
      2'd0: return "R2/R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // inputs are set; check outputs mid-cycle, then advance the model across the edge
  task automatic run_cycle(input string req);
    logic [3:0] e;
    logic [1:0] m;
    string t;
    #1;
    m = exp_mode[pkt_idx_i];
    e = exp_route(pkt_valid_i, m, pkt_op_i, pkt_ovf_i, sw_ready_i);
    t = (req != "") ? req : tag_of(m, e[2] && !sw_ready_i);
    chk(t, "route {hw,sw,busy,ready}", {hw_valid_o, sw_valid_o, busy_o, pkt_ready_o}, e);
    chk("R8", "readback", cfg_mode_o, exp_mode[cfg_idx_i]);
    if (e[2] && sw_ready_i) exp_mode[pkt_idx_i] = 2'd1;
    if (cfg_we_i) exp_mode[cfg_idx_i] = cfg_mode_i;
    @(negedge clk_i);
  endtask

  task automatic idle();
    pkt_valid_i = 0; cfg_we_i = 0;
  endtask

  task automatic write_mode(input int idx, input logic [1:0] m);
    idle();
    cfg_we_i = 1; cfg_idx_i = IDX_W'(idx); cfg_mode_i = m;
    run_cycle("R8");
    cfg_we_i = 0;
  endtask

  task automatic read_chk(input string req, input int idx, input logic [1:0] m);
    idle();
    cfg_idx_i = IDX_W'(idx);
    #1;
    chk(req, "mode readback", cfg_mode_o, m);
  endtask

  task automatic send(input int idx, input logic [2:0] op, input logic ovf, input logic rdy, input string req);
    pkt_valid_i = 1; pkt_idx_i = IDX_W'(idx); pkt_op_i = op; pkt_ovf_i = ovf; sw_ready_i = rdy;
    run_cycle(req);
    pkt_valid_i = 0; sw_ready_i = 1;
  endtask

  initial begin : watchdog
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < ENTRIES; i++) exp_mode[i] = 2'd0;
    #12;
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1: all entries start in hardware mode
    for (int i = 0; i < ENTRIES; i++) begin
      cfg_idx_i = IDX_W'(i); #1;
      chk("R1", "reset mode", cfg_mode_o, 0);
      @(negedge clk_i);
    end

    // R11: hardware-routed packet leaves mode alone
    send(2, 3'd1, 1'b0, 1'b1, "R2");
    read_chk("R11", 2, 2'd0);
    // R3: overflow forwards and locks
    send(2, 3'd0, 1'b1, 1'b1, "R3");
    read_chk("R3", 2, 2'd1);
    // R6: locked, queue has room -> stall; queue full -> busy
    send(2, 3'd0, 1'b0, 1'b1, "R6");
    send(2, 3'd0, 1'b0, 1'b0, "R6");
    read_chk("R6", 2, 2'd1);
    // R4: trap-writes mode
    @(negedge clk_i);
    write_mode(4, 2'd2);
    send(4, 3'd0, 1'b0, 1'b1, "R4");
    send(4, 3'd4, 1'b0, 1'b1, "R4");
    read_chk("R4", 4, 2'd2);
    send(4, 3'd2, 1'b0, 1'b1, "R4");
    read_chk("R4", 4, 2'd1);
    // R7: forward against full queue stalls, mode kept
    @(negedge clk_i);
    write_mode(5, 2'd3);
    send(5, 3'd0, 1'b0, 1'b0, "R7");
    read_chk("R7", 5, 2'd3);
    // R5 and R10: trap-all locks only its own entry
    @(negedge clk_i);
    send(5, 3'd4, 1'b0, 1'b1, "R5");
    read_chk("R5", 5, 2'd1);
    read_chk("R10", 6, 2'd0);
    read_chk("R10", 4, 2'd1);
    // R9: same-cycle software write beats the lock
    @(negedge clk_i);
    write_mode(7, 2'd3);
    cfg_we_i = 1; cfg_idx_i = IDX_W'(7); cfg_mode_i = 2'd2;
    send(7, 3'd1, 1'b0, 1'b1, "R9");
    cfg_we_i = 0;
    read_chk("R9", 7, 2'd2);
    @(negedge clk_i);

    // constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      pkt_valid_i = ($urandom_range(0, 3) != 0);
      pkt_idx_i   = IDX_W'($urandom_range(0, ENTRIES - 1));
      pkt_op_i    = 3'($urandom_range(0, 7));
      pkt_ovf_i   = ($urandom_range(0, 4) == 0);
      sw_ready_i  = ($urandom_range(0, 3) != 0);
      cfg_we_i    = ($urandom_range(0, 4) == 0);
      cfg_idx_i   = (cfg_we_i && $urandom_range(0, 3) == 0) ? pkt_idx_i
                                                             : IDX_W'($urandom_range(0, ENTRIES - 1));
      cfg_mode_i  = 2'($urandom_range(0, 3));
      run_cycle("");
    end
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule